// File: doc/BRIEF.md
# Two-Wire Configuration Bus Slave

This block terminates a two-wire configuration bus made of a master-driven clock and a shared data line. The master sends 16-bit command frames, most significant bit first. Each frame holds a marker bit that is always 1, then a direction bit, then a 6-bit register address, then a data byte. The block turns write frames into single-cycle pulses on a register-file write port. For read frames, it fetches the addressed byte through a read port and drives that byte back on the data line while the master clocks the low half of the frame.

The data line also carries transmit data when the bus is not in configuration use. Because of this, the slave ignores frames until it sees an entry sequence. That sequence is a run of at least 32 bus clocks with data low, then the entry code 0x8D00. The code 0x8D02 leaves configuration mode. The code 0xBD01 produces a soft-reset pulse for the radio section. The bus clock and data inputs are brought into the system clock domain through two-flop synchronizers. The system clock must run at least 8 times faster than the bus clock.

Top module: `cfg_bus_slave`

## Requirements
- R1: The slave samples the data line on each falling edge of the bus clock. A frame is 16 bits, MSB first: bit 15 is the marker (1), bit 14 selects read (1) or write (0), bits 13:8 are the address and bits 7:0 are the data.
- R2: After at least 32 consecutive low data samples followed by frame 0x8D00, `cfg_mode_o` goes high. A run of 31 low samples followed by 0x8D00 leaves it low.
- R3: Frame 0x8D02 received in configuration mode clears `cfg_mode_o`. The bus then ignores frames until the next entry sequence.
- R4: Frame 0xBD01, whether received in configuration mode or as the first frame after the low run, gives exactly one system-clock pulse on `soft_rst_o`.
- R5: A write frame in configuration mode gives one single-cycle `reg_we_o` pulse, with `reg_waddr_o` set to bits 13:8 and `reg_wdata_o` set to bits 7:0. A write frame outside configuration mode gives no pulse.
- R6: The frames 0x8D00, 0x8D02 and 0xBD01 never produce a register-file write.
- R7: For a read frame in configuration mode, the slave presents bits 13:8 on `reg_raddr_o`. It then drives the returned byte on `bus_dat_o`, MSB first, with `bus_dat_oe_o` high. Each data bit is valid before the falling edge that ends frame bits 7 down to 0. The enable drops once the frame ends.
- R8: If a frame begins with a 0 bit, the slave discards it and loses alignment. It ignores all later frames until another low run of at least 32 samples, followed by a 1 bit, realigns it. `cfg_mode_o` is not changed by this.
- R9: Out of reset, `cfg_mode_o`, `reg_we_o`, `soft_rst_o` and `bus_dat_oe_o` are low.
- R10: Outside configuration mode, a read frame never raises `bus_dat_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Bus clock from master |
| bus_dat_i | input | 1 | Bus data line as received |
| bus_dat_o | output | 1 | Read-return data bit |
| bus_dat_oe_o | output | 1 | Drive enable for bus_dat_o |
| reg_we_o | output | 1 | Register-file write strobe |
| reg_waddr_o | output | 6 | Write address |
| reg_wdata_o | output | 8 | Write data |
| reg_raddr_o | output | 6 | Read address |
| reg_rdata_i | input | 8 | Read data, combinational from reg_raddr_o |
| cfg_mode_o | output | 1 | Configuration mode active |
| soft_rst_o | output | 1 | Soft-reset pulse for the radio section |

## Verification
The assertions assume that the master changes data only while the bus clock is high. They also assume that each bus-clock phase lasts several system clocks, so that each falling edge yields exactly one sample after synchronization. They further assume that `reg_rdata_i` settles within one system cycle of `reg_raddr_o`. The bench drives every bit with fixed 6-cycle phases and changes data together with the rising edge. The random frames always keep the marker bit set; zero-marker frames appear only in the directed discard case.

// File: rtl/cfg_bus_pkg.sv
package cfg_bus_pkg;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int HW = 2 + AW;
  localparam int FW = HW + DW;

  localparam logic [FW-1:0] CODE_ENTER = 16'h8D00;
  localparam logic [FW-1:0] CODE_EXIT  = 16'h8D02;
  localparam logic [FW-1:0] CODE_SRST  = 16'hBD01;

  typedef struct packed {
    logic          mark;
    logic          rd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } frame_t;
endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) q[i] <= '0;
    end else begin
      q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/cfg_bus_framer.sv
module cfg_bus_framer
  import cfg_bus_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sdat_i,
  input  logic          keep_i,
  output logic          bit_stb_o,
  output logic          hdr_vld_o,
  output logic [HW-2:0] hdr_o,
  output logic          frame_vld_o,
  output frame_t        frame_o
);
  localparam int CW = $clog2(FW);
  localparam int ZW = $clog2(PRE_LEN + 1);

  logic          sclk_q;
  logic          aligned;
  logic [CW-1:0] bit_cnt;
  logic [ZW-1:0] zero_cnt;
  logic [FW-2:0] shreg;

  assign bit_stb_o = sclk_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      aligned     <= 1'b0;
      bit_cnt     <= '0;
      zero_cnt    <= '0;
      shreg       <= '0;
      hdr_vld_o   <= 1'b0;
      hdr_o       <= '0;
      frame_vld_o <= 1'b0;
      frame_o     <= '0;
    end else begin
      sclk_q      <= sclk_i;
      hdr_vld_o   <= 1'b0;
      frame_vld_o <= 1'b0;
      if (bit_stb_o) begin
        if (!aligned) begin
          if (!sdat_i) begin
            if (zero_cnt != ZW'(PRE_LEN)) zero_cnt <= zero_cnt + 1'b1;
          end else begin
            zero_cnt <= '0;
            if (zero_cnt == ZW'(PRE_LEN)) begin
              aligned <= 1'b1;
              bit_cnt <= CW'(1);
              shreg   <= FW'(1);
            end
          end
        end else if (bit_cnt == '0 && !sdat_i) begin
          // marker missing: drop frame, this zero opens a new low run
          aligned  <= 1'b0;
          zero_cnt <= ZW'(1);
        end else begin
          shreg   <= {shreg[FW-3:0], sdat_i};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CW'(HW - 1)) begin
            hdr_vld_o <= 1'b1;
            hdr_o     <= {shreg[HW-3:0], sdat_i};
          end
          if (bit_cnt == CW'(FW - 1)) begin
            frame_vld_o <= 1'b1;
            frame_o     <= {shreg, sdat_i};
            bit_cnt     <= '0;
          end
        end
      end else if (frame_vld_o && !keep_i) begin
        aligned  <= 1'b0;
        zero_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/cfg_bus_cmd.sv
module cfg_bus_cmd
  import cfg_bus_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_stb_i,
  input  logic          hdr_vld_i,
  input  logic [HW-2:0] hdr_i,
  input  logic          frame_vld_i,
  input  frame_t        frame_i,
  input  logic [DW-1:0] rdata_i,
  output logic          keep_o,
  output logic          cfg_mode_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [AW-1:0] raddr_o,
  output logic          dat_o,
  output logic          oe_o,
  output logic          soft_o
);
  logic          magic;
  logic          cfg_d;
  logic          rd_pend;
  logic [DW-1:0] out_sr;

  always_comb begin
    magic = (frame_i == CODE_ENTER) || (frame_i == CODE_EXIT) ||
            (frame_i == CODE_SRST);
    cfg_d = cfg_mode_o;
    if (frame_vld_i) begin
      if (frame_i == CODE_ENTER)                    cfg_d = 1'b1;
      else if (cfg_mode_o && frame_i == CODE_EXIT)  cfg_d = 1'b0;
    end
  end

  assign keep_o = cfg_d;
  assign dat_o  = out_sr[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_mode_o <= 1'b0;
      we_o       <= 1'b0;
      waddr_o    <= '0;
      wdata_o    <= '0;
      raddr_o    <= '0;
      soft_o     <= 1'b0;
      rd_pend    <= 1'b0;
      out_sr     <= '0;
      oe_o       <= 1'b0;
    end else begin
      cfg_mode_o <= cfg_d;
      we_o       <= 1'b0;
      soft_o     <= 1'b0;
      rd_pend    <= 1'b0;
      if (hdr_vld_i && hdr_i[HW-2] && cfg_mode_o) begin
        raddr_o <= hdr_i[AW-1:0];
        rd_pend <= 1'b1;
      end
      if (rd_pend) begin
        out_sr <= rdata_i;
        oe_o   <= 1'b1;
      end else if (bit_stb_i && oe_o) begin
        out_sr <= {out_sr[DW-2:0], 1'b0};
      end
      if (frame_vld_i) begin
        oe_o   <= 1'b0;
        soft_o <= (frame_i == CODE_SRST);
        if (cfg_mode_o && !frame_i.rd && !magic) begin
          we_o    <= 1'b1;
          waddr_o <= frame_i.addr;
          wdata_o <= frame_i.data;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_bus_slave.sv
module cfg_bus_slave
  import cfg_bus_pkg::*;
#(
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_clk_i,
  input  logic          bus_dat_i,
  output logic          bus_dat_o,
  output logic          bus_dat_oe_o,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_waddr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic [AW-1:0] reg_raddr_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          cfg_mode_o,
  output logic          soft_rst_o
);
  logic [1:0]    sync_q;
  logic          bit_stb, hdr_vld, frame_vld, keep;
  logic [HW-2:0] hdr;
  frame_t        frame;

  cfg_bus_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({bus_clk_i, bus_dat_i}),
    .q_o    (sync_q)
  );

  cfg_bus_framer #(.PRE_LEN(PRE_LEN)) i_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sync_q[1]),
    .sdat_i      (sync_q[0]),
    .keep_i      (keep),
    .bit_stb_o   (bit_stb),
    .hdr_vld_o   (hdr_vld),
    .hdr_o       (hdr),
    .frame_vld_o (frame_vld),
    .frame_o     (frame)
  );

  cfg_bus_cmd i_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_stb_i   (bit_stb),
    .hdr_vld_i   (hdr_vld),
    .hdr_i       (hdr),
    .frame_vld_i (frame_vld),
    .frame_i     (frame),
    .rdata_i     (reg_rdata_i),
    .keep_o      (keep),
    .cfg_mode_o  (cfg_mode_o),
    .we_o        (reg_we_o),
    .waddr_o     (reg_waddr_o),
    .wdata_o     (reg_wdata_o),
    .raddr_o     (reg_raddr_o),
    .dat_o       (bus_dat_o),
    .oe_o        (bus_dat_oe_o),
    .soft_o      (soft_rst_o)
  );
endmodule

// File: rtl/cfg_bus_slave_chk.sv
module cfg_bus_slave_chk
  import cfg_bus_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_mode_o,
  input logic          reg_we_o,
  input logic [AW-1:0] reg_waddr_o,
  input logic [DW-1:0] reg_wdata_o,
  input logic          soft_rst_o,
  input logic          bus_dat_oe_o
);
  logic [FW-1:0] wr_frame;
  assign wr_frame = {2'b10, reg_waddr_o, reg_wdata_o};

  a_r4_soft_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  a_r5_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r5_we_in_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> cfg_mode_o);

  a_r6_no_magic_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (wr_frame != CODE_ENTER && wr_frame != CODE_EXIT &&
                  wr_frame != CODE_SRST));

  a_r10_oe_in_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dat_oe_o |-> cfg_mode_o);

  a_r7_oe_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dat_oe_o |-> !reg_we_o);
endmodule

bind cfg_bus_slave cfg_bus_slave_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_mode_o   (cfg_mode_o),
  .reg_we_o     (reg_we_o),
  .reg_waddr_o  (reg_waddr_o),
  .reg_wdata_o  (reg_wdata_o),
  .soft_rst_o   (soft_rst_o),
  .bus_dat_oe_o (bus_dat_oe_o)
);

// File: tb/test_cfg_bus_slave.sv
module test_cfg_bus_slave;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_clk = 1'b0;
  logic       bus_dat = 1'b0;
  logic       dat_o, oe_o, we_o, cfg_o, srst_o;
  logic [5:0] waddr, raddr;
  logic [7:0] wdata, rdata;

  int checks = 0, errors = 0;
  int we_cnt = 0, soft_cnt = 0;
  logic [5:0] last_waddr = '0;
  logic [7:0] last_wdata = '0;
  bit model_cfg = 0, model_al = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rd_model(input logic [5:0] a);
    return {a, 2'b01} ^ 8'hC3;
  endfunction

  assign rdata = rd_model(raddr);

  cfg_bus_slave i_cfg_bus_slave (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bus_clk), .bus_dat_i(bus_dat),
    .bus_dat_o(dat_o), .bus_dat_oe_o(oe_o), .reg_we_o(we_o),
    .reg_waddr_o(waddr), .reg_wdata_o(wdata), .reg_raddr_o(raddr),
    .reg_rdata_i(rdata), .cfg_mode_o(cfg_o), .soft_rst_o(srst_o)
  );

  always @(negedge clk) begin
    if (we_o) begin
      we_cnt++;
      last_waddr = waddr;
      last_wdata = wdata;
    end
    if (srst_o) soft_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit: data changes with rising edge, slave samples at falling edge
  task automatic send_bit(input logic b, output logic d, output logic oe);
    @(negedge clk);
    bus_dat = b;
    bus_clk = 1'b1;
    wait_clk(HALF);
    d  = dat_o;
    oe = oe_o;
    bus_clk = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send_zeros(input int n);
    logic d, oe;
    for (int i = 0; i < n; i++) send_bit(1'b0, d, oe);
  endtask

  task automatic send_raw(input logic [15:0] f, output logic [7:0] rd,
                          output int oe_lo, output int oe_hi);
    logic d, oe;
    oe_lo = 0; oe_hi = 0; rd = '0;
    for (int i = 15; i >= 0; i--) begin
      send_bit(f[i], d, oe);
      if (i < 8) begin
        rd[i] = d;
        if (oe) oe_lo++;
      end else if (oe) oe_hi++;
    end
    wait_clk(4);
  endtask

  task automatic preamble();
    send_zeros(32);
    model_al = 1;
  endtask

  task automatic do_frame(input logic [15:0] f, input string tag);
    logic [7:0] rd;
    int oe_lo, oe_hi, we0, so0;
    bit magic, exp_we, exp_oe, exp_so, nxt;
    magic  = (f == 16'h8D00) || (f == 16'h8D02) || (f == 16'hBD01);
    exp_so = model_al && f == 16'hBD01;
    exp_we = model_al && model_cfg && !f[14] && !magic;
    exp_oe = model_al && model_cfg && f[14];
    nxt    = model_cfg;
    if (model_al && f == 16'h8D00) nxt = 1;
    else if (model_al && model_cfg && f == 16'h8D02) nxt = 0;
    we0 = we_cnt; so0 = soft_cnt;
    send_raw(f, rd, oe_lo, oe_hi);
    chk(we_cnt - we0 == int'(exp_we), {tag, " R5/R6 write count"}, we_cnt - we0, int'(exp_we));
    if (exp_we)
      chk({last_waddr, last_wdata} == f[13:0], {tag, " R1 write fields"},
          {last_waddr, last_wdata}, f[13:0]);
    chk(soft_cnt - so0 == int'(exp_so), {tag, " R4 soft reset"}, soft_cnt - so0, int'(exp_so));
    chk(cfg_o == nxt, {tag, " R2/R3 cfg mode"}, cfg_o, nxt);
    if (exp_oe) begin
      chk(rd == rd_model(f[13:8]), {tag, " R7 read data"}, rd, rd_model(f[13:8]));
      chk(oe_lo == 8 && oe_hi == 0, {tag, " R7 oe window"}, oe_lo * 16 + oe_hi, 8 * 16);
    end else begin
      chk(oe_lo + oe_hi == 0, {tag, " R10 oe idle"}, oe_lo + oe_hi, 0);
    end
    chk(oe_o == 1'b0, {tag, " R7 oe released"}, oe_o, 0);
    if (model_al) model_al = nxt;
    model_cfg = nxt;
  endtask

  initial begin
    logic [7:0] rd;
    int oe_lo, oe_hi, we0;
    void'($urandom(32'd1234));
    wait_clk(5);
    chk(!cfg_o && !oe_o && !we_o && !srst_o, "R9 reset state",
        {cfg_o, oe_o, we_o, srst_o}, 0);
    rst_n = 1'b1;
    wait_clk(5);
    chk(!cfg_o && !oe_o && !we_o && !srst_o, "R9 after release",
        {cfg_o, oe_o, we_o, srst_o}, 0);

    send_zeros(31);
    do_frame(16'h8D00, "R2 short run");
    preamble();
    do_frame(16'hEA00, "R10 read outside cfg");
    preamble();
    do_frame(16'h92AA, "R5 write outside cfg");
    preamble();
    do_frame(16'hBD01, "R4 soft after run");
    preamble();
    do_frame(16'h8D00, "R2 entry");
    do_frame(16'h92AA, "R5 write");
    do_frame(16'hEA00, "R7 read");
    do_frame(16'hBD01, "R4 soft in cfg");
    do_frame(16'h8D00, "R6 enter again");
    do_frame(16'hFF5A, "R7 read top addr");

    we0 = we_cnt;
    send_raw(16'h12AA, rd, oe_lo, oe_hi);
    model_al = 0;
    chk(we_cnt == we0, "R8 discarded frame", we_cnt - we0, 0);
    chk(cfg_o == 1'b1, "R8 cfg kept", cfg_o, 1);
    do_frame(16'h92AA, "R8 unaligned write");
    preamble();
    do_frame(16'h9F3C, "R8 realigned write");

    for (int n = 0; n < 60; n++) begin
      logic [15:0] f;
      if (!model_al) begin
        preamble();
        if (!model_cfg) do_frame(16'h8D00, "R2 re-entry");
      end
      case ($urandom % 10)
        0: f = 16'hBD01;
        1: f = 16'h8D02;
        2: f = 16'h8D00;
        default: f = {1'b1, 15'($urandom)};
      endcase
      do_frame(f, "R1 random");
    end

    if (!model_al) begin
      preamble();
      do_frame(16'h8D00, "R2 entry final");
    end
    do_frame(16'h8D02, "R3 exit");
    do_frame(16'h92AA, "R3 ignored after exit");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule